// File: doc/BRIEF.md
# Indirectly Configured GPIO Controller

This block controls 29 general-purpose pins, grouped into four 8-bit ports. Pin n belongs to port n/8 at bit n%8. A host reaches the block through a byte-wide register window. Each port has a data register at its own offset. A write to a data register loads the output latches of that port. A read of a data register returns the pad levels after they pass a two-flop synchronizer. Software changes a single pin by reading the port, editing the byte and writing it back.

The drive mode of each pin is set indirectly, in two steps. The host first writes a selector byte that names a port and a bit. It then reads or writes a three-bit configuration byte for the selected pin. That byte holds the drive enable, push-pull or open-drain drive, and the pull-up enable. From each pin's configuration and latch, the block produces three pad controls: output level, output enable and pull-up.

A two-state machine tracks whether the selector points at a pin that exists. The states are `ST_NO_PIN` (reset state, nothing selected) and `ST_PIN_HELD` (a pin that exists is selected). There are three transitions. `T_SEL_OK` is a selector write naming a pin below 29, and it leads to `ST_PIN_HELD`. `T_SEL_BAD` is a selector write naming pin 29 to 31, and it leads to `ST_NO_PIN`. `T_HOLD` covers every other cycle, and the state does not change.

Top module: `gpio_indirect_ctrl`

## Requirements
- R1: During and after reset, `pad_out`, `pad_oe` and `pad_pu` are all 0. `rdata` is 0, and the selector state is `ST_NO_PIN`.
- R2: A write to a port data register loads the output latches of that port's pins, with wdata bit k going to pin port*8+k. The port data registers are at offsets 0x00, 0x04, 0x08 and 0x0A for ports 0 to 3. The new latch values act on the pad controls from the cycle after the write.
- R3: A read with `rd_en` returns its result on `rdata` in the next cycle, and `rdata` holds it until the next read. Reading a port data register returns that port's `pad_in` bits as they were two clock edges earlier.
- R4: The selector register is at offset 0x10. Bits [5:4] hold the port and bits [2:0] hold the bit index. Bits 7, 6 and 3 are ignored and read back as 0. A write whose pin number port*8+bit is below 29 moves the state to `ST_PIN_HELD`. Any other selector write moves it to `ST_NO_PIN`.
- R5: The configuration register is at offset 0x11. Bit 0 is the drive enable, bit 1 selects push-pull (1) or open-drain (0), and bit 2 is the pull-up enable. Bits [7:3] read as 0. In `ST_NO_PIN`, configuration writes are ignored and configuration reads return 0.
- R6: A pin with its drive enable clear has `pad_oe` = 0. In push-pull mode, `pad_oe` equals the drive enable and `pad_out` equals the latch. In open-drain mode, `pad_out` is 0 and `pad_oe` is the drive enable ANDed with the inverted latch.
- R7: `pad_pu` of each pin equals the pull-up bit of that pin's configuration.
- R8: In port 3, bits [7:5] read as 0 and writes to them have no effect. Reads of any offset outside the window return 0, and writes to such offsets change nothing.
- R9: A configuration write changes only the selected pin. The pad controls change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register window offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pad_in | input | 29 | Pad input levels |
| pad_out | output | 29 | Pad output levels |
| pad_oe | output | 29 | Pad output enables |
| pad_pu | output | 29 | Pad pull-up enables |

## Verification
The hardest case to reach is a configuration access while the selector names a pin that does not exist. Only selector bytes for ports 3 with bit 5 to 7 lead there. The stimulus writes all 256 selector values and reads each one back. After every value that leaves the machine in `ST_NO_PIN`, it writes a full configuration and confirms that no pad control moved.

A second sweep visits every pin with all eight configuration codes and both latch values. After each step it compares all three pad vectors against a model, so a change that leaks onto a neighbouring pin is caught.

// File: rtl/gpio_ic_pkg.sv
package gpio_ic_pkg;

    localparam int BYTE_W       = 8;
    localparam int SEL_BIT_W    = 3;
    localparam int SEL_PORT_W   = 2;
    localparam int SEL_PORT_LSB = 4;
    localparam int CFG_W        = 3;

    typedef enum logic {
        ST_NO_PIN,
        ST_PIN_HELD
    } sel_state_t;

    // bit 0 drive enable, bit 1 push-pull, bit 2 pull-up
    typedef struct packed {
        logic pull_up;
        logic push_pull;
        logic drive_en;
    } pin_cfg_t;

    // Port data register offsets: 4-byte spacing for the first three ports,
    // then 2-byte spacing.
    function automatic logic [7:0] port_offset(input int p);
        if (p < 3) begin
            return 8'(p * 4);
        end
        return 8'(10 + (p - 3) * 2);
    endfunction

endpackage

// File: rtl/gpio_ic_decode.sv
module gpio_ic_decode
    import gpio_ic_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_PORTS = 4,
    parameter int SEL_OFS   = 16,
    parameter int CFG_OFS   = 17
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PORTS-1:0] port_hit,
    output logic                 sel_hit,
    output logic                 cfg_hit
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_hit
        assign port_hit[p] = (addr == ADDR_W'(port_offset(p)));
    end

    assign sel_hit = (addr == ADDR_W'(SEL_OFS));
    assign cfg_hit = (addr == ADDR_W'(CFG_OFS));

endmodule

// File: rtl/gpio_ic_pinsel.sv
module gpio_ic_pinsel
    import gpio_ic_pkg::*;
#(
    parameter int NUM_PINS = 29,
    localparam int PIN_W   = SEL_PORT_W + SEL_BIT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_wr,
    input  logic [SEL_PORT_W-1:0] sel_port_in,
    input  logic [SEL_BIT_W-1:0]  sel_bit_in,
    output logic                  sel_valid,
    output logic [PIN_W-1:0]      sel_pin,
    output logic [BYTE_W-1:0]     sel_rb
);

    sel_state_t       state_q;
    sel_state_t       state_d;
    logic [PIN_W-1:0] pin_q;
    logic             req_ok;

    assign req_ok = (int'({sel_port_in, sel_bit_in}) < NUM_PINS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NO_PIN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_SEL_OK, T_SEL_BAD, otherwise T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NO_PIN: begin
                if (sel_wr && req_ok) begin
                    state_d = ST_PIN_HELD;
                end
            end
            ST_PIN_HELD: begin
                if (sel_wr && !req_ok) begin
                    state_d = ST_NO_PIN;
                end
            end
        endcase
    end

    // selector fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else if (sel_wr) begin
            pin_q <= {sel_port_in, sel_bit_in};
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_NO_PIN:   sel_valid = 1'b0;
            ST_PIN_HELD: sel_valid = 1'b1;
        endcase
        sel_pin = pin_q;
        sel_rb  = BYTE_W'({pin_q[PIN_W-1:SEL_BIT_W], 1'b0, pin_q[SEL_BIT_W-1:0]});
    end

endmodule

// File: rtl/gpio_ic_cfg_bank.sv
module gpio_ic_cfg_bank
    import gpio_ic_pkg::*;
#(
    parameter int NUM_PINS = 29,
    parameter int PIN_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    sel_valid,
    input  logic [PIN_W-1:0]        sel_pin,
    input  pin_cfg_t                cfg_in,
    output pin_cfg_t [NUM_PINS-1:0] cfg_q,
    output pin_cfg_t                cfg_sel
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_slot
        pin_cfg_t slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (cfg_wr && sel_valid && (sel_pin == PIN_W'(i))) begin
                slot_q <= cfg_in;
            end
        end
        assign cfg_q[i] = slot_q;
    end

    always_comb begin
        cfg_sel = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_pin == PIN_W'(i)) begin
                cfg_sel = cfg_q[i];
            end
        end
    end

endmodule

// File: rtl/gpio_ic_port_bank.sv
module gpio_ic_port_bank
    import gpio_ic_pkg::*;
#(
    parameter int NUM_PINS  = 29,
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_wr,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  lat_q,
    output logic [NUM_PINS-1:0]  sync_q
);

    logic [NUM_PINS-1:0] meta_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_latch
        localparam int PORT = i / BYTE_W;
        localparam int BIT  = i % BYTE_W;
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (port_wr[PORT]) begin
                bit_q <= wdata[BIT];
            end
        end
        assign lat_q[i] = bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_indirect_ctrl.sv
module gpio_indirect_ctrl
    import gpio_ic_pkg::*;
#(
    parameter int NUM_PINS = 29,
    parameter int ADDR_W   = 8,
    parameter int SEL_OFS  = 16,
    parameter int CFG_OFS  = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);

    localparam int NUM_PORTS = (NUM_PINS + BYTE_W - 1) / BYTE_W;
    localparam int PIN_W     = SEL_PORT_W + SEL_BIT_W;
    localparam int EXT_W     = NUM_PORTS * BYTE_W;

    logic [NUM_PORTS-1:0]    port_hit;
    logic                    sel_hit;
    logic                    cfg_hit;
    logic                    sel_valid;
    logic [PIN_W-1:0]        sel_pin;
    logic [BYTE_W-1:0]       sel_rb;
    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    pin_cfg_t                cfg_sel;
    logic [NUM_PINS-1:0]     lat_q;
    logic [NUM_PINS-1:0]     sync_q;
    logic [EXT_W-1:0]        sync_ext;
    logic [BYTE_W-1:0]       rd_mux;

    gpio_ic_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PORTS(NUM_PORTS),
        .SEL_OFS  (SEL_OFS),
        .CFG_OFS  (CFG_OFS)
    ) u_decode (
        .addr    (addr),
        .port_hit(port_hit),
        .sel_hit (sel_hit),
        .cfg_hit (cfg_hit)
    );

    gpio_ic_pinsel #(
        .NUM_PINS(NUM_PINS)
    ) u_pinsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (wr_en & sel_hit),
        .sel_port_in(wdata[SEL_PORT_LSB +: SEL_PORT_W]),
        .sel_bit_in (wdata[SEL_BIT_W-1:0]),
        .sel_valid  (sel_valid),
        .sel_pin    (sel_pin),
        .sel_rb     (sel_rb)
    );

    gpio_ic_cfg_bank #(
        .NUM_PINS(NUM_PINS),
        .PIN_W   (PIN_W)
    ) u_cfg_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (wr_en & cfg_hit),
        .sel_valid(sel_valid),
        .sel_pin  (sel_pin),
        .cfg_in   (pin_cfg_t'(wdata[CFG_W-1:0])),
        .cfg_q    (cfg_q),
        .cfg_sel  (cfg_sel)
    );

    gpio_ic_port_bank #(
        .NUM_PINS (NUM_PINS),
        .NUM_PORTS(NUM_PORTS)
    ) u_port_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .port_wr({NUM_PORTS{wr_en}} & port_hit),
        .wdata  (wdata),
        .pad_in (pad_in),
        .lat_q  (lat_q),
        .sync_q (sync_q)
    );

    // pad drive per pin
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        assign pad_oe[i]  = cfg_q[i].drive_en & (cfg_q[i].push_pull | ~lat_q[i]);
        assign pad_out[i] = cfg_q[i].push_pull & lat_q[i];
        assign pad_pu[i]  = cfg_q[i].pull_up;
    end

    assign sync_ext = EXT_W'(sync_q);

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) begin
                rd_mux = sync_ext[p*BYTE_W +: BYTE_W];
            end
        end
        if (sel_hit) begin
            rd_mux = sel_rb;
        end
        if (cfg_hit && sel_valid) begin
            rd_mux = BYTE_W'(cfg_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_indirect_ctrl_chk.sv
module gpio_indirect_ctrl_chk
    import gpio_ic_pkg::*;
#(
    parameter int NUM_PINS = 29,
    parameter int ADDR_W   = 8,
    parameter int SEL_OFS  = 16,
    parameter int CFG_OFS  = 17
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [7:0]          rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_pu,
    input logic                sel_valid
);

    localparam int NUM_PORTS = (NUM_PINS + 7) / 8;
    localparam int SPARE     = NUM_PORTS * 8 - NUM_PINS;
    localparam logic [7:0] HI_MASK = 8'(8'hFF << (8 - SPARE));

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = (a == ADDR_W'(SEL_OFS)) || (a == ADDR_W'(CFG_OFS));
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (a == ADDR_W'(port_offset(p))) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (pad_oe == '0 && pad_out == '0 && pad_pu == '0);
        end
    end

    p_pad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_mapped(addr)) |=> (rdata == 8'h00));

    p_port3_spare_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(port_offset(NUM_PORTS - 1))) |=> ((rdata & HI_MASK) == 8'h00));

    p_sel_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(SEL_OFS)) |=> (rdata[7:6] == 2'b00 && !rdata[3]));

    p_cfg_nosel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(CFG_OFS) && !sel_valid) |=> (rdata == 8'h00));

    p_cfg_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(CFG_OFS)) |=> (rdata[7:3] == 5'b00000));

endmodule

bind gpio_indirect_ctrl gpio_indirect_ctrl_chk #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W),
    .SEL_OFS (SEL_OFS),
    .CFG_OFS (CFG_OFS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .sel_valid(sel_valid)
);

// File: tb/gpio_indirect_ctrl_tb_top.sv
module gpio_indirect_ctrl_tb_top;

    localparam int NP = 29;
    localparam logic [7:0] A_SEL = 8'h10;
    localparam logic [7:0] A_CFG = 8'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_pu;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    logic [2:0]    m_cfg [NP];
    logic [NP-1:0] m_lat = '0;

    always #2.5 clk = ~clk;

    gpio_indirect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    function automatic logic [7:0] port_addr(input int p);
        return (p < 3) ? 8'(p * 4) : 8'h0A;
    endfunction

    function automatic logic is_mapped(input logic [7:0] a);
        return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0A ||
               a == A_SEL || a == A_CFG;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check_pads(input string req);
        logic [NP-1:0] e_oe, e_out, e_pu;
        for (int i = 0; i < NP; i++) begin
            e_pu[i]  = m_cfg[i][2];
            e_out[i] = m_cfg[i][1] & m_lat[i];
            e_oe[i]  = m_cfg[i][0] & (m_cfg[i][1] | ~m_lat[i]);
        end
        chk({req, " pad_oe"}, 32'(pad_oe), 32'(e_oe));
        chk({req, " pad_out"}, 32'(pad_out), 32'(e_out));
        chk({req, " pad_pu"}, 32'(pad_pu), 32'(e_pu));
    endtask

    task automatic write_port(input int p, input logic [7:0] v);
        wr(port_addr(p), v);
        for (int k = 0; k < 8; k++) begin
            if (p * 8 + k < NP) m_lat[p*8+k] = v[k];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < NP; i++) m_cfg[i] = 3'b000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_pads("R1 during reset");
        chk("R1 rdata in reset", 32'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pads("R1 after reset");
        rd(A_SEL, d); chk("R1 selector reset", 32'(d), 0);
        rd(A_CFG, d); chk("R1 R5 no pin at reset", 32'(d), 0);

        // R4 / R5: sweep all selector bytes
        for (int v = 0; v < 256; v++) begin
            logic [7:0] m;
            int pin;
            m = 8'(v) & 8'h37;
            pin = int'(m[5:4]) * 8 + int'(m[2:0]);
            wr(A_SEL, 8'(v));
            rd(A_SEL, d); chk("R4 selector readback", 32'(d), 32'(m));
            if (pin >= NP) begin
                wr(A_CFG, 8'h07);
                check_pads("R5 write ignored without pin");
                rd(A_CFG, d); chk("R5 read zero without pin", 32'(d), 0);
            end
        end

        // R5 R6 R7 R9: every pin, every config code, both latch values
        for (int pin = 0; pin < NP; pin++) begin
            int p, b;
            p = pin / 8; b = pin % 8;
            wr(A_SEL, 8'((p << 4) | b));
            for (int c = 0; c < 8; c++) begin
                wr(A_CFG, 8'(c) | 8'hF8);
                m_cfg[pin] = 3'(c);
                rd(A_CFG, d); chk("R5 config readback", 32'(d), 32'(c));
                for (int l = 0; l < 2; l++) begin
                    logic [7:0] pv;
                    for (int k = 0; k < 8; k++) pv[k] = (p * 8 + k < NP) ? m_lat[p*8+k] : 1'b0;
                    pv[b] = l[0];
                    write_port(p, pv);
                    check_pads("R6 R7 R9 pad controls");
                end
            end
            wr(A_CFG, 8'(pin % 8));
            m_cfg[pin] = 3'(pin % 8);
            check_pads("R9 neighbour isolation");
        end

        // R2 R8: all pins push-pull outputs, then port patterns
        for (int pin = 0; pin < NP; pin++) begin
            wr(A_SEL, 8'(((pin / 8) << 4) | (pin % 8)));
            wr(A_CFG, 8'h03);
            m_cfg[pin] = 3'b011;
        end
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pats [4];
            pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'hFF; pats[3] = 8'h3C;
            for (int k = 0; k < 4; k++) begin
                write_port(p, pats[k]);
                check_pads("R2 R8 port write");
            end
        end

        // R3: synchronizer latency
        pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in = 29'h1FFF_FFFF;
        rd(8'h00, d); chk("R3 old level one edge after change", 32'(d), 0);
        rd(8'h00, d); chk("R3 new level after two edges", 32'(d), 32'hFF);

        // R3 R8: pad level patterns
        for (int t = 0; t < NP + 3; t++) begin
            logic [NP-1:0] pat;
            if (t < NP) pat = NP'(1) << t;
            else if (t == NP) pat = '1;
            else if (t == NP + 1) pat = 29'h1555_5555;
            else pat = 29'h0AAA_AAAA;
            pad_in = pat;
            repeat (3) @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                logic [31:0] ext;
                ext = 32'(pat);
                rd(port_addr(p), d);
                chk("R3 R8 port read", 32'(d), 32'(ext[p*8 +: 8]));
            end
        end

        // R8: unmapped offsets
        pad_in = '1;
        wr(A_SEL, 8'h12);
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            if (!is_mapped(8'(a))) begin
                wr(8'(a), 8'hFF);
                rd(8'(a), d);
                chk("R8 unmapped read", 32'(d), 0);
            end
        end
        check_pads("R8 unmapped writes ignored");
        rd(A_SEL, d); chk("R8 selector untouched", 32'(d), 32'h12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule